// File: doc/BRIEF.md
# Window-limit watchdog monitor

The monitor watches digitized samples arriving from two channels and compares each one against a lower and an upper limit kept separately for every channel. A sample that falls below its channel's lower limit, or rises above its upper limit, pulls an active-low interrupt low. It also pulls one of two active-low direction flags low, so the host can tell which side of the window was left without reading anything back. The flags and the interrupt stay low until the host drops chip select, which returns all three to high in one step.

Limits are written one at a time through a small write port: channel number, a side select and the value. The chip-select line also steers the operating mode. The block comes out of reset watching. A high pulse on chip select that lasts fewer than `SHORT_LIM` oscillator clocks, followed by a fall, takes the block out of watching so the next frame can set up other work. Holding chip select high for `SHORT_LIM` clocks puts it back into watching. All logic runs on the oscillator clock.

Top module: `wdm_monitor`

## Requirements
- R1: After reset, int_n, lo_cross_n and hi_cross_n are high, wd_mode is high, every lower limit is 0 and every upper limit is 255.
- R2: While wd_mode is high, a valid sample strictly below its channel's lower limit drives int_n and lo_cross_n low on the clock edge that takes the sample.
- R3: While wd_mode is high, a valid sample strictly above its channel's upper limit drives int_n and hi_cross_n low on the clock edge that takes the sample.
- R4: A sample equal to either limit, or between them, changes no output.
- R5: A limit write (lim_upper 0 selects the lower limit, 1 the upper) takes effect from the next clock; a sample taken in the same cycle as the write is compared against the old value.
- R6: A chip-select fall (cs_n sampled high on one edge and low on the next) returns int_n, lo_cross_n and hi_cross_n to high.
- R7: When a crossing and a chip-select fall are taken on the same edge, the old alerts are cleared and the new crossing is reported.
- R8: A chip-select fall after a high run of fewer than SHORT_LIM clocks (default 8) drives wd_mode low; while wd_mode is low, samples raise no alert.
- R9: With wd_mode low, the SHORT_LIM-th consecutive clock edge with cs_n high drives wd_mode high, and crossings are reported again.
- R10: Both direction flags can be low together, and each stays low, whatever cs_n does, until a chip-select fall.
- R11: Each channel is judged only against its own limit pair; smp_chan selects the channel (0 or 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| smp_valid | input | 1 | Sample strobe |
| smp_chan | input | CW | Channel of the sample |
| smp_data | input | DW | Unsigned sample value |
| lim_we | input | 1 | Limit write strobe |
| lim_chan | input | CW | Channel of the limit write |
| lim_upper | input | 1 | 0 writes the lower limit, 1 the upper |
| lim_data | input | DW | Limit value |
| int_n | output | 1 | Active-low interrupt |
| lo_cross_n | output | 1 | Low when a lower limit was crossed |
| hi_cross_n | output | 1 | Low when an upper limit was crossed |
| wd_mode | output | 1 | High while the block is watching |

## Verification
A chip-select fall clears the alerts, and a new crossing sets them, and both can be taken on the same clock edge. The bench drops chip select in the same cycle that it presents a below-limit sample. It expects int_n and lo_cross_n to stay low and hi_cross_n, which was set before, to return high. A second same-edge case writes an upper limit and samples against it in one cycle, and expects the comparison to use the old limit.

// File: rtl/wdm_pkg.sv
package wdm_pkg;

    typedef enum logic {
        SIDE_LOWER = 1'b0,
        SIDE_UPPER = 1'b1
    } lim_side_e;

    typedef struct packed {
        logic int_n;
        logic lo_n;
        logic hi_n;
    } alert_t;

    localparam alert_t ALERT_IDLE = '{int_n: 1'b1, lo_n: 1'b1, hi_n: 1'b1};

endpackage

// File: rtl/wdm_limit_bank.sv
module wdm_limit_bank
    import wdm_pkg::*;
#(
    parameter int NCH = 2,
    parameter int DW  = 8,
    parameter int CW  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CW-1:0]     wr_chan,
    input  lim_side_e         wr_side,
    input  logic [DW-1:0]     wr_data,
    output logic [NCH*DW-1:0] lower_flat,
    output logic [NCH*DW-1:0] upper_flat
);

    typedef struct packed {
        logic [DW-1:0] lower;
        logic [DW-1:0] upper;
    } pair_t;

    localparam pair_t PAIR_RESET = '{lower: '0, upper: '1};

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        pair_t pair_d, pair_q;
        logic  hit;

        assign hit = wr_en && (wr_chan == CW'(c));

        always_comb begin
            pair_d = pair_q;
            if (hit) begin
                if (wr_side == SIDE_UPPER) begin
                    pair_d.upper = wr_data;
                end else begin
                    pair_d.lower = wr_data;
                end
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pair_q <= PAIR_RESET;
            end else begin
                pair_q <= pair_d;
            end
        end

        assign lower_flat[c*DW +: DW] = pair_q.lower;
        assign upper_flat[c*DW +: DW] = pair_q.upper;
    end

endmodule

// File: rtl/wdm_window_cmp.sv
module wdm_window_cmp #(
    parameter int NCH = 2,
    parameter int DW  = 8,
    parameter int CW  = 1
) (
    input  logic [CW-1:0]     chan,
    input  logic [DW-1:0]     data,
    input  logic [NCH*DW-1:0] lower_flat,
    input  logic [NCH*DW-1:0] upper_flat,
    output logic              below,
    output logic              above
);

    logic [NCH-1:0] below_vec;
    logic [NCH-1:0] above_vec;
    logic [NCH-1:0] sel_vec;

    for (genvar c = 0; c < NCH; c++) begin : g_cmp
        assign sel_vec[c]   = (chan == CW'(c));
        assign below_vec[c] = data < lower_flat[c*DW +: DW];
        assign above_vec[c] = data > upper_flat[c*DW +: DW];
    end

    assign below = |(below_vec & sel_vec);
    assign above = |(above_vec & sel_vec);

endmodule

// File: rtl/wdm_cs_timer.sv
module wdm_cs_timer #(
    parameter int SHORT_LIM = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    output logic cs_fall,
    output logic wd_mode
);

    localparam int CNTW = $clog2(SHORT_LIM + 1);
    localparam logic [CNTW-1:0] LIM_C  = CNTW'(SHORT_LIM);
    localparam logic [CNTW-1:0] LAST_C = CNTW'(SHORT_LIM - 1);

    typedef struct packed {
        logic [CNTW-1:0] cnt;
        logic            prev;
        logic            wd;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d      = tmr_q;
        tmr_d.prev = cs_n;
        cs_fall    = !cs_n && tmr_q.prev;
        if (cs_n) begin
            if (tmr_q.cnt < LIM_C) begin
                tmr_d.cnt = tmr_q.cnt + 1'b1;
            end
            if (tmr_q.cnt >= LAST_C) begin
                tmr_d.wd = 1'b1;
            end
        end else begin
            tmr_d.cnt = '0;
            if (cs_fall && (tmr_q.cnt < LIM_C)) begin
                tmr_d.wd = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '{cnt: LIM_C, prev: 1'b1, wd: 1'b1};
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign wd_mode = tmr_q.wd;

endmodule

// File: rtl/wdm_monitor.sv
module wdm_monitor
    import wdm_pkg::*;
#(
    parameter int NCH       = 2,
    parameter int DW        = 8,
    parameter int SHORT_LIM = 8,
    parameter int CW        = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          smp_valid,
    input  logic [CW-1:0] smp_chan,
    input  logic [DW-1:0] smp_data,
    input  logic          lim_we,
    input  logic [CW-1:0] lim_chan,
    input  logic          lim_upper,
    input  logic [DW-1:0] lim_data,
    output logic          int_n,
    output logic          lo_cross_n,
    output logic          hi_cross_n,
    output logic          wd_mode
);

    logic [NCH*DW-1:0] lower_flat;
    logic [NCH*DW-1:0] upper_flat;
    logic              below;
    logic              above;
    logic              cs_fall;
    logic              watch;

    wdm_limit_bank #(.NCH(NCH), .DW(DW), .CW(CW)) u_limits (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (lim_we),
        .wr_chan    (lim_chan),
        .wr_side    (lim_side_e'(lim_upper)),
        .wr_data    (lim_data),
        .lower_flat (lower_flat),
        .upper_flat (upper_flat)
    );

    wdm_window_cmp #(.NCH(NCH), .DW(DW), .CW(CW)) u_cmp (
        .chan       (smp_chan),
        .data       (smp_data),
        .lower_flat (lower_flat),
        .upper_flat (upper_flat),
        .below      (below),
        .above      (above)
    );

    wdm_cs_timer #(.SHORT_LIM(SHORT_LIM)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_n    (cs_n),
        .cs_fall (cs_fall),
        .wd_mode (watch)
    );

    alert_t alert_d, alert_q;
    logic   judge;

    // Clear first, then let a crossing on the same edge win.
    always_comb begin
        judge   = watch && smp_valid;
        alert_d = cs_fall ? ALERT_IDLE : alert_q;
        if (judge && below) begin
            alert_d.lo_n  = 1'b0;
            alert_d.int_n = 1'b0;
        end
        if (judge && above) begin
            alert_d.hi_n  = 1'b0;
            alert_d.int_n = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            alert_q <= ALERT_IDLE;
        end else begin
            alert_q <= alert_d;
        end
    end

    assign int_n      = alert_q.int_n;
    assign lo_cross_n = alert_q.lo_n;
    assign hi_cross_n = alert_q.hi_n;
    assign wd_mode    = watch;

endmodule

// File: rtl/wdm_monitor_chk.sv
module wdm_monitor_chk #(
    parameter int NCH = 2,
    parameter int DW  = 8,
    parameter int CW  = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              smp_valid,
    input logic [CW-1:0]     smp_chan,
    input logic [DW-1:0]     smp_data,
    input logic [NCH*DW-1:0] lower_flat,
    input logic [NCH*DW-1:0] upper_flat,
    input logic              int_n,
    input logic              lo_cross_n,
    input logic              hi_cross_n,
    input logic              wd_mode
);

    logic [DW-1:0] sel_lo;
    logic [DW-1:0] sel_hi;

    always_comb begin
        sel_lo = '0;
        sel_hi = '1;
        for (int c = 0; c < NCH; c++) begin
            if (smp_chan == CW'(c)) begin
                sel_lo = lower_flat[c*DW +: DW];
                sel_hi = upper_flat[c*DW +: DW];
            end
        end
    end

    assert_lo_cross_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_mode && smp_valid && (smp_data < sel_lo)) |=> (!int_n && !lo_cross_n));

    assert_hi_cross_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_mode && smp_valid && (smp_data > sel_hi)) |=> (!int_n && !hi_cross_n));

    assert_inside_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (int_n && !$fell(cs_n) && (!smp_valid || ((smp_data >= sel_lo) && (smp_data <= sel_hi))))
        |=> int_n);

    assert_fall_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cs_n) && !smp_valid) |=> (int_n && lo_cross_n && hi_cross_n));

    assert_idle_ignores_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!wd_mode && int_n) |=> int_n);

    assert_lo_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!lo_cross_n && !$fell(cs_n)) |=> !lo_cross_n);

    assert_hi_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!hi_cross_n && !$fell(cs_n)) |=> !hi_cross_n);

endmodule

bind wdm_monitor wdm_monitor_chk #(.NCH(NCH), .DW(DW), .CW(CW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n       (cs_n),
    .smp_valid  (smp_valid),
    .smp_chan   (smp_chan),
    .smp_data   (smp_data),
    .lower_flat (lower_flat),
    .upper_flat (upper_flat),
    .int_n      (int_n),
    .lo_cross_n (lo_cross_n),
    .hi_cross_n (hi_cross_n),
    .wd_mode    (wd_mode)
);

// File: tb/wdm_monitor_bench.sv
module wdm_monitor_bench;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       smp_valid = 1'b0;
    logic [0:0] smp_chan = '0;
    logic [7:0] smp_data = '0;
    logic       lim_we = 1'b0;
    logic [0:0] lim_chan = '0;
    logic       lim_upper = 1'b0;
    logic [7:0] lim_data = '0;
    logic       int_n, lo_cross_n, hi_cross_n, wd_mode;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    typedef struct {
        logic  i;
        logic  l;
        logic  h;
        logic  w;
        string tag;
    } exp_t;

    exp_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    wdm_monitor u_wdm_monitor (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n       (cs_n),
        .smp_valid  (smp_valid),
        .smp_chan   (smp_chan),
        .smp_data   (smp_data),
        .lim_we     (lim_we),
        .lim_chan   (lim_chan),
        .lim_upper  (lim_upper),
        .lim_data   (lim_data),
        .int_n      (int_n),
        .lo_cross_n (lo_cross_n),
        .hi_cross_n (hi_cross_n),
        .wd_mode    (wd_mode)
    );

    // Monitor: one expected item per clock edge, judged after the edge settles.
    always @(posedge clk) begin
        #(CLK_PERIOD/4);
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            checks++;
            if ({int_n, lo_cross_n, hi_cross_n, wd_mode} !== {e.i, e.l, e.h, e.w}) begin
                fails++;
                $display("FAIL %s: got int_n=%b lo=%b hi=%b wd=%b, expected %b %b %b %b",
                         e.tag, int_n, lo_cross_n, hi_cross_n, wd_mode, e.i, e.l, e.h, e.w);
            end
        end
    end

    task automatic step(input logic cs, input logic v, input logic ch, input logic [7:0] d,
                        input logic we, input logic wch, input logic wup, input logic [7:0] wv,
                        input logic ei, input logic el, input logic eh, input logic ew,
                        input string tag);
        exp_t e;
        @(negedge clk);
        cs_n      = cs;
        smp_valid = v;
        smp_chan  = ch;
        smp_data  = d;
        lim_we    = we;
        lim_chan  = wch;
        lim_upper = wup;
        lim_data  = wv;
        e.i = ei; e.l = el; e.h = eh; e.w = ew; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        checks++;
        fails++;
        $display("FAIL watchdog: got no end of run, expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        checks++;
        if ({int_n, lo_cross_n, hi_cross_n, wd_mode} !== 4'b1111) begin
            fails++;
            $display("FAIL R1 reset: got %b%b%b%b, expected 1111",
                     int_n, lo_cross_n, hi_cross_n, wd_mode);
        end

        // R1: default window passes extremes on both channels
        step(1, 1, 0, 8'd0,   0, 0, 0, 8'd0, 1, 1, 1, 1, "R1 default lower limit 0");
        step(1, 1, 1, 8'd255, 0, 0, 0, 8'd0, 1, 1, 1, 1, "R1 default upper limit 255");
        // Program limits: ch0 [50,200], ch1 [10,20]
        step(1, 0, 0, 8'd0, 1, 0, 0, 8'd50,  1, 1, 1, 1, "R5 write ch0 lower");
        step(1, 0, 0, 8'd0, 1, 0, 1, 8'd200, 1, 1, 1, 1, "R5 write ch0 upper");
        step(1, 0, 0, 8'd0, 1, 1, 0, 8'd10,  1, 1, 1, 1, "R5 write ch1 lower");
        step(1, 0, 0, 8'd0, 1, 1, 1, 8'd20,  1, 1, 1, 1, "R5 write ch1 upper");
        step(1, 1, 0, 8'd100, 0, 0, 0, 8'd0, 1, 1, 1, 1, "R4 inside window");
        step(1, 1, 0, 8'd50,  0, 0, 0, 8'd0, 1, 1, 1, 1, "R4 equal lower limit");
        step(1, 1, 0, 8'd200, 0, 0, 0, 8'd0, 1, 1, 1, 1, "R4 equal upper limit");
        step(1, 1, 1, 8'd100, 0, 0, 0, 8'd0, 0, 1, 0, 1, "R11 R3 ch1 own upper limit");
        step(0, 0, 0, 8'd0,   0, 0, 0, 8'd0, 1, 1, 1, 1, "R6 cs fall clears alerts");
        step(0, 1, 0, 8'd49,  0, 0, 0, 8'd0, 0, 0, 1, 1, "R2 below lower limit");
        step(0, 1, 0, 8'd201, 0, 0, 0, 8'd0, 0, 0, 0, 1, "R10 both flags low");
        for (int k = 0; k < 8; k++)
            step(1, 0, 0, 8'd0, 0, 0, 0, 8'd0, 0, 0, 0, 1, "R10 flags held with cs high");
        step(0, 1, 1, 8'd5, 0, 0, 0, 8'd0, 0, 0, 1, 1, "R7 cs fall and crossing same edge");
        for (int k = 0; k < 8; k++)
            step(1, 0, 0, 8'd0, 0, 0, 0, 8'd0, 0, 0, 1, 1, "R10 lo flag held");
        step(0, 0, 0, 8'd0, 0, 0, 0, 8'd0, 1, 1, 1, 1, "R6 cs fall after long high keeps watching");
        step(0, 1, 0, 8'd150, 1, 0, 1, 8'd100, 1, 1, 1, 1, "R5 same-cycle write uses old limit");
        step(0, 1, 0, 8'd150, 0, 0, 0, 8'd0,   0, 1, 0, 1, "R5 new upper limit applies");
        for (int k = 0; k < 3; k++)
            step(1, 0, 0, 8'd0, 0, 0, 0, 8'd0, 0, 1, 0, 1, "R8 short high pulse in progress");
        step(0, 0, 0, 8'd0, 0, 0, 0, 8'd0, 1, 1, 1, 0, "R8 short pulse leaves watching");
        step(0, 1, 0, 8'd0, 0, 0, 0, 8'd0, 1, 1, 1, 0, "R8 sample ignored when not watching");
        for (int k = 0; k < 7; k++)
            step(1, 1, 0, 8'd255, 0, 0, 0, 8'd0, 1, 1, 1, 0, "R9 R8 not yet watching");
        step(1, 0, 0, 8'd0, 0, 0, 0, 8'd0, 1, 1, 1, 1, "R9 watching after SHORT_LIM high clocks");
        step(1, 1, 0, 8'd0, 0, 0, 0, 8'd0, 0, 0, 1, 1, "R9 crossing reported again");
        step(1, 0, 0, 8'd0, 0, 0, 0, 8'd0, 0, 0, 1, 1, "R10 idle hold");
        repeat (3) @(negedge clk);
        done = 1'b1;
        finish_run();
    end

endmodule